// File: doc/BRIEF.md
# Multi-Mode 16-Bit Barrel Shifter

This block shifts or rotates a 16-bit word by 0 to 15 positions in a single combinational pass. It is meant to sit in the shift unit of an arithmetic and logic unit. The caller supplies the operand, a 4-bit distance, a 3-bit operation code and the current carry flag. It gets back the shifted word and the carry value to store. The carry flag register belongs to the caller.

There is only one shifting structure, a four-stage logarithmic right shifter. Each stage moves the word by a power of two when its distance bit is set. A fill word sits above the operand, and its bits flow into the vacated top positions. Left-going operations reverse the operand on the way in and reverse the result on the way out, so the same right shifter serves both directions. A small fill generator chooses what enters for each operation: sign copies, zeros, the operand itself for rotation, or the carry flag for a one-step rotate through carry.

The block has no clock and no state, so there are no states or transitions to name. The result follows the inputs in the same cycle.

Top module: `shf_barrel16`

## Requirements
- R1: Operation code 0 is arithmetic right shift: `data_out` equals `data_in` shifted right by `shift_amt`, with copies of bit 15 filling the top.
- R2: Operation code 1 is logical right shift, with zeros entering at bit 15.
- R3: Operation code 2 is logical left shift, with zeros entering at bit 0.
- R4: Operation code 3 rotates right by `shift_amt`: bits leaving bit 0 re-enter at bit 15.
- R5: Operation code 4 rotates left by `shift_amt`: bits leaving bit 15 re-enter at bit 0.
- R6: Operation code 5 rotates right through carry by exactly one position for any nonzero `shift_amt`. The result is `{carry_in, data_in[15:1]}` and `carry_out` is `data_in[0]`.
- R7: Operation code 6 rotates left through carry by exactly one position for any nonzero `shift_amt`. The result is `{data_in[14:0], carry_in}` and `carry_out` is `data_in[15]`.
- R8: When `shift_amt` is 0, `data_out` equals `data_in` and `carry_out` equals `carry_in`, whatever the operation code.
- R9: For operation codes 0 to 4, `carry_out` equals `carry_in`.
- R10: Operation code 7 is reserved. It passes `data_in` through unchanged and keeps the carry.
- R11: The block is purely combinational. The outputs reflect the present inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 16 | Operand word |
| shift_amt | input | 4 | Shift or rotate distance, 0 to 15 |
| mode | input | 3 | Operation code (see R1 to R10) |
| carry_in | input | 1 | Current carry flag |
| data_out | output | 16 | Shifted or rotated word |
| carry_out | output | 1 | Carry value for the caller to store |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and either output. The driver applies each stimulus just after a rising edge and queues the expected word and carry. The monitor compares them at the following falling edge, half a period later, so the combinational paths have settled by then. One further check changes the inputs with no clock edge at all and samples one nanosecond later, to show that no edge is needed.

// File: rtl/shf_pkg.sv
package shf_pkg;

    parameter int unsigned SHF_W = 16;
    localparam int unsigned SHF_AW = $clog2(SHF_W);

    typedef enum logic [2:0] {
        SHF_ASR  = 3'd0,
        SHF_LSR  = 3'd1,
        SHF_LSL  = 3'd2,
        SHF_ROR  = 3'd3,
        SHF_ROL  = 3'd4,
        SHF_RCR  = 3'd5,
        SHF_RCL  = 3'd6,
        SHF_PASS = 3'd7
    } shf_mode_e;

endpackage

// File: rtl/shf_bit_rev.sv
module shf_bit_rev #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] din,
    input  logic         en,
    output logic [W-1:0] dout
);
    logic [W-1:0] flipped;

    for (genvar i = 0; i < W; i++) begin : g_flip
        assign flipped[i] = din[W-1-i];
    end

    assign dout = en ? flipped : din;
endmodule

// File: rtl/shf_fill_gen.sv
module shf_fill_gen
    import shf_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  shf_mode_e    mode,
    input  logic [W-1:0] operand,
    input  logic         carry_in,
    output logic [W-1:0] fill
);
    always_comb begin
        unique case (mode)
            SHF_ASR:          fill = {W{operand[W-1]}};
            SHF_LSR, SHF_LSL: fill = '0;
            SHF_ROR, SHF_ROL: fill = operand;
            SHF_RCR, SHF_RCL: fill = {{(W-1){1'b0}}, carry_in};
            SHF_PASS:         fill = '0;
        endcase
    end
endmodule

// File: rtl/shf_right_core.sv
module shf_right_core #(
    parameter int unsigned W  = 16,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [W-1:0]  fill,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    localparam int unsigned CW = 2 * W;

    logic [CW-1:0] stage [0:AW];

    assign stage[0] = {fill, din};

    for (genvar s = 0; s < AW; s++) begin : g_stage
        assign stage[s+1] = amt[s] ? (stage[s] >> (1 << s)) : stage[s];
    end

    assign dout = stage[AW][W-1:0];

    always_comb begin
        if (amt == '0) begin
            AST_CORE_IDENTITY: assert (dout == din); // R8
        end
    end
endmodule

// File: rtl/shf_barrel16.sv
module shf_barrel16
    import shf_pkg::*;
#(
    parameter  int unsigned W  = SHF_W,
    localparam int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  data_in,
    input  logic [AW-1:0] shift_amt,
    input  logic [2:0]    mode,
    input  logic          carry_in,
    output logic [W-1:0]  data_out,
    output logic          carry_out
);
    shf_mode_e     op_mode;
    logic          is_left;
    logic          is_carry_rot;
    logic          is_rotate;
    logic [AW-1:0] eff_amt;
    logic [W-1:0]  operand;
    logic [W-1:0]  fill;
    logic [W-1:0]  core_out;

    assign op_mode      = shf_mode_e'(mode);
    assign is_left      = (op_mode == SHF_LSL) || (op_mode == SHF_ROL) || (op_mode == SHF_RCL);
    assign is_carry_rot = (op_mode == SHF_RCR) || (op_mode == SHF_RCL);
    assign is_rotate    = (op_mode == SHF_ROR) || (op_mode == SHF_ROL);

    always_comb begin
        if (op_mode == SHF_PASS) begin
            eff_amt = '0;
        end else if (is_carry_rot) begin
            eff_amt = {{(AW-1){1'b0}}, |shift_amt};
        end else begin
            eff_amt = shift_amt;
        end
    end

    shf_bit_rev #(.W(W)) i_rev_in (
        .din  (data_in),
        .en   (is_left),
        .dout (operand)
    );

    shf_fill_gen #(.W(W)) i_fill (
        .mode     (op_mode),
        .operand  (operand),
        .carry_in (carry_in),
        .fill     (fill)
    );

    shf_right_core #(.W(W), .AW(AW)) i_core (
        .din  (operand),
        .fill (fill),
        .amt  (eff_amt),
        .dout (core_out)
    );

    shf_bit_rev #(.W(W)) i_rev_out (
        .din  (core_out),
        .en   (is_left),
        .dout (data_out)
    );

    assign carry_out = (is_carry_rot && (eff_amt != '0)) ? operand[0] : carry_in;

    always_comb begin
        if (shift_amt == '0 || op_mode == SHF_PASS) begin
            AST_ZERO_PASS: assert (data_out == data_in && carry_out == carry_in); // R8
        end
        if (!is_carry_rot) begin
            AST_CARRY_HOLD: assert (carry_out == carry_in); // R9
        end
        if (is_rotate) begin
            AST_ROT_KEEPS_ONES: assert ($countones(data_out) == $countones(data_in)); // R4
        end
        if (is_carry_rot) begin
            AST_RC_KEEPS_ONES: assert ($countones({data_out, carry_out}) == $countones({data_in, carry_in})); // R6
        end
        if (op_mode == SHF_ASR) begin
            AST_ASR_SIGN: assert (data_out[W-1] == data_in[W-1]); // R1
        end
        if (op_mode == SHF_LSL && shift_amt != '0) begin
            AST_LSL_LOW_ZERO: assert (data_out[0] == 1'b0); // R3
        end
    end
endmodule

// File: tb/test_shf_barrel16.sv
module test_shf_barrel16;

    typedef struct {
        logic [15:0] res;
        logic        cy;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] data_in = '0;
    logic [3:0]  shift_amt = '0;
    logic [2:0]  mode = '0;
    logic        carry_in = 1'b0;
    logic [15:0] data_out;
    logic        carry_out;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    shf_barrel16 i_shf_barrel16 (
        .data_in   (data_in),
        .shift_amt (shift_amt),
        .mode      (mode),
        .carry_in  (carry_in),
        .data_out  (data_out),
        .carry_out (carry_out)
    );

    function automatic exp_t model(input logic [15:0] d, input int a,
                                   input int m, input logic c);
        exp_t        e;
        logic [31:0] dbl;
        dbl   = {d, d};
        e.cy  = c;
        e.res = d;
        case (m)
            0: begin e.res = 16'($signed(d) >>> a); e.tag = "R1"; end
            1: begin e.res = d >> a;                e.tag = "R2"; end
            2: begin e.res = d << a;                e.tag = "R3"; end
            3: begin e.res = dbl[a +: 16];          e.tag = "R4"; end
            4: begin e.res = dbl[(16 - a) +: 16];   e.tag = "R5"; end
            5: begin
                e.tag = "R6";
                if (a != 0) begin e.res = {c, d[15:1]}; e.cy = d[0]; end
            end
            6: begin
                e.tag = "R7";
                if (a != 0) begin e.res = {d[14:0], c}; e.cy = d[15]; end
            end
            default: e.tag = "R10";
        endcase
        if (a == 0) e.tag = {e.tag, " R8"};
        if (m <= 4) e.tag = {e.tag, " R9"};
        return e;
    endfunction

    task automatic compare(input exp_t e);
        n_checks++;
        if (data_out !== e.res || carry_out !== e.cy) begin
            n_fail++;
            $display("FAIL %s: got data=%h carry=%b, expected data=%h carry=%b",
                     e.tag, data_out, carry_out, e.res, e.cy);
        end
    endtask

    task automatic drive(input logic [15:0] d, input int a, input int m, input logic c);
        @(posedge clk);
        #1;
        data_in   = d;
        shift_amt = 4'(a);
        mode      = 3'(m);
        carry_in  = c;
        sb.push_back(model(d, a, m, c));
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) compare(sb.pop_front());
    end

    initial begin
        exp_t z;
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [4] = '{16'h8001, 16'hA5C3, 16'h7FFE, 16'h0000};
        int          amts [5] = '{0, 1, 5, 8, 15};
        exp_t        e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        e.res = 16'h0000; e.cy = 1'b0; e.tag = "reset R8";
        compare(e);
        rst = 1'b0;

        for (int m = 0; m < 8; m++)
            for (int ai = 0; ai < 5; ai++)
                for (int pi = 0; pi < 4; pi++)
                    for (int c = 0; c < 2; c++)
                        drive(pats[pi], amts[ai], m, 1'(c));

        // R6 R7: a large distance still moves one position
        drive(16'h0001, 15, 5, 1'b0);
        drive(16'h8000, 9, 6, 1'b1);

        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);

        // R11: outputs follow inputs without a clock edge
        #2;
        data_in = 16'h1234; shift_amt = 4'd4; mode = 3'd3; carry_in = 1'b0;
        #1;
        e = model(16'h1234, 4, 3, 1'b0);
        e.tag = "R11";
        compare(e);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule